// File: doc/BRIEF.md
# Write Command Queue with Busy Flag

This block is a first-in first-out buffer between the host write ports of a multichannel converter and the engine that applies register updates. The host pushes one 24-bit write instruction per cycle. Each instruction carries a register-select field, a group/channel address and a data word. The host can keep pushing while earlier instructions are still being carried out downstream. The host write path has no back-pressure. A push that meets a full queue is discarded without any indication.

The consumer takes instructions one at a time through a ready/valid handshake, strictly in arrival order. It raises `exec_done` for one cycle when it has finished the instruction it last took. The active-low `busy_n` output stays low while work is pending: either instructions are still queued, or the last popped one has not finished. Either host interface, parallel or serial, feeds the same push port. Any choice between them happens upstream.

Top module: `cmd_write_queue`

## Requirements
- R1: In the cycle after synchronous active-high reset `rst` is released, `pop_valid` is 0 and `busy_n` is 1. The queue is empty.
- R2: A push into an empty queue makes `pop_valid` high in the next cycle, with that word on `pop_word`.
- R3: Words leave on `pop_word` in exactly the order they were accepted. `pop_word` always shows the oldest stored word.
- R4: With no pops, exactly DEPTH (default 120) back-to-back pushes are accepted. The stored count never exceeds DEPTH.
- R5: A push while the queue holds DEPTH words and no pop happens in that cycle is dropped. The stored words and their order are unchanged.
- R6: A push and a pop in the same cycle on a full queue both take effect, and the queue stays full.
- R7: `busy_n` is 0 in every cycle where the queue is non-empty or a popped instruction has not yet been finished. A pop handshake sets the unfinished state. `exec_done` clears it unless another pop happens in the same cycle. `busy_n` rises only in the cycle after `exec_done`.
- R8: A pop handshake occurs when `pop_valid` and `pop_ready` are both 1, and it removes one word. While `pop_ready` is 0, `pop_valid` and `pop_word` hold steady.
- R9: The word passes through unchanged, laid out as bits [23:22] register select, [21:14] group/channel address and [13:0] data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Host offers a write instruction this cycle |
| push_word | input | 24 | Instruction: select [23:22], address [21:14], data [13:0] |
| pop_ready | input | 1 | Consumer accepts the head word this cycle |
| exec_done | input | 1 | Consumer finished the last popped instruction |
| pop_valid | output | 1 | Queue holds at least one word |
| pop_word | output | 24 | Oldest stored instruction |
| busy_n | output | 1 | Low while queued or unfinished work remains |

## Verification
The bench builds the block at the default depth of 120, which is not a power of two. This selects the pointer variant that wraps explicitly at the last slot. It also makes the fill-to-capacity run, the dropped overflow pushes and the push-while-full-with-pop case reachable within a few hundred cycles. Random traffic runs several thousand cycles with the consumer's ready and completion strobes varied. This drives the pointers through many wraps and lets the busy flag both stay low across back-to-back pops and rise after the final completion.

// File: rtl/cwq_pkg.sv
package cwq_pkg;
   localparam int CWQ_SEL_W  = 2;
   localparam int CWQ_ADDR_W = 8;
   localparam int CWQ_DATA_W = 14;
   localparam int CWQ_WORD_W = CWQ_SEL_W + CWQ_ADDR_W + CWQ_DATA_W;
   localparam int CWQ_DEPTH  = 120;

   function automatic bit cwq_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/cwq_ptr.sv
module cwq_ptr #(
   parameter int DEPTH = 120,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [PW-1:0] ptr
);
   import cwq_pkg::*;

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $fatal(1, "cwq_ptr: DEPTH must be at least 2");
   end

   generate
      if (cwq_is_pow2(DEPTH)) begin : g_natural_wrap
         always_ff @(posedge clk) begin
            if (rst)      ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_explicit_wrap
         always_ff @(posedge clk) begin
            if (rst)      ptr <= '0;
            else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst) begin
         // R3
         ptr_range_chk: assert (ptr <= LAST)
            else $error("pointer beyond last slot");
      end
   end
endmodule

// File: rtl/cwq_storage.sv
module cwq_storage #(
   parameter int DEPTH  = 120,
   parameter int WORD_W = 24,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] slots [DEPTH];

   initial begin
      if (WORD_W < 1) $fatal(1, "cwq_storage: WORD_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (we) slots[waddr] <= wdata;
   end

   assign rdata = slots[raddr];
endmodule

// File: rtl/cwq_track.sv
module cwq_track (
   input  logic clk,
   input  logic rst,
   input  logic pop_fire,
   input  logic exec_done,
   input  logic not_empty,
   output logic busy_n
);
   logic inflight;

   always_ff @(posedge clk) begin
      if (rst)            inflight <= 1'b0;
      else if (pop_fire)  inflight <= 1'b1;
      else if (exec_done) inflight <= 1'b0;
   end

   assign busy_n = ~(not_empty | inflight);

   // R7
   pop_makes_busy_chk: assert property (@(posedge clk) disable iff (rst)
      pop_fire |=> !busy_n);

   // R7
   rise_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_n) |-> $past(exec_done));

   // R1
   idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> busy_n);
endmodule

// File: rtl/cmd_write_queue.sv
module cmd_write_queue #(
   parameter int DEPTH  = cwq_pkg::CWQ_DEPTH,
   parameter int SEL_W  = cwq_pkg::CWQ_SEL_W,
   parameter int ADDR_W = cwq_pkg::CWQ_ADDR_W,
   parameter int DATA_W = cwq_pkg::CWQ_DATA_W,
   localparam int WORD_W = SEL_W + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_valid,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop_ready,
   input  logic              exec_done,
   output logic              pop_valid,
   output logic [WORD_W-1:0] pop_word,
   output logic              busy_n
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   initial begin
      if (DEPTH < 2)  $fatal(1, "cmd_write_queue: DEPTH must be at least 2");
      if (SEL_W < 1)  $fatal(1, "cmd_write_queue: SEL_W must be positive");
      if (ADDR_W < 1) $fatal(1, "cmd_write_queue: ADDR_W must be positive");
      if (DATA_W < 1) $fatal(1, "cmd_write_queue: DATA_W must be positive");
   end

   logic [CW-1:0] count;
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          empty, full, pop_fire, push_fire;

   assign empty     = (count == '0);
   assign full      = (count == FULL_CNT);
   assign pop_fire  = pop_ready & ~empty;
   assign push_fire = push_valid & (~full | pop_fire);

   always_ff @(posedge clk) begin
      if (rst)                      count <= '0;
      else if (push_fire & ~pop_fire) count <= count + 1'b1;
      else if (pop_fire & ~push_fire) count <= count - 1'b1;
   end

   cwq_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
      .clk (clk), .rst (rst), .adv (push_fire), .ptr (wr_ptr)
   );

   cwq_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
      .clk (clk), .rst (rst), .adv (pop_fire), .ptr (rd_ptr)
   );

   cwq_storage #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk   (clk),
      .we    (push_fire),
      .waddr (wr_ptr),
      .wdata (push_word),
      .raddr (rd_ptr),
      .rdata (pop_word)
   );

   cwq_track u_track (
      .clk       (clk),
      .rst       (rst),
      .pop_fire  (pop_fire),
      .exec_done (exec_done),
      .not_empty (~empty),
      .busy_n    (busy_n)
   );

   assign pop_valid = ~empty;

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      count <= FULL_CNT);

   // R2
   push_shows_chk: assert property (@(posedge clk) disable iff (rst)
      (push_valid && !pop_valid) |=> (pop_valid && pop_word == $past(push_word)));

   // R5
   full_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (full && push_valid && !pop_ready) |=> (full && $stable(pop_word)));

   // R6
   full_swap_chk: assert property (@(posedge clk) disable iff (rst)
      (full && push_valid && pop_ready) |=> full);

   // R8
   hold_head_chk: assert property (@(posedge clk) disable iff (rst)
      (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_word)));
endmodule

// File: tb/cmd_write_queue_tb.sv
`timescale 1ns/1ps
module cmd_write_queue_tb;
   localparam int DEPTH = 120;
   localparam int W = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic push_valid = 1'b0;
   logic [W-1:0] push_word = '0;
   logic pop_ready = 1'b0;
   logic exec_done = 1'b0;
   logic pop_valid, busy_n;
   logic [W-1:0] pop_word;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] mq[$];
   bit m_inflight = 0;
   int pops_seen = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   cmd_write_queue #(.DEPTH(DEPTH)) u_dut (
      .clk (clk), .rst (rst), .push_valid (push_valid), .push_word (push_word),
      .pop_ready (pop_ready), .exec_done (exec_done),
      .pop_valid (pop_valid), .pop_word (pop_word), .busy_n (busy_n)
   );

   function automatic logic [W-1:0] mk(input int i);
      // R9: select [23:22], address [21:14], data [13:0]
      logic [1:0]  s = 2'(i);
      logic [7:0]  a = 8'(i * 7 + 3);
      logic [13:0] d = 14'(i * 37 + 11);
      return {s, a, d};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      // R8: pop_valid follows non-empty state
      chk(pop_valid == (mq.size() != 0), "R8", W'(pop_valid), W'(mq.size() != 0));
      // R3 / R9: head word, fields intact
      if (mq.size() != 0) chk(pop_word == mq[0], "R3", pop_word, mq[0]);
      // R7: busy low when work pending
      chk(busy_n == !((mq.size() != 0) || m_inflight), "R7", W'(busy_n),
          W'(!((mq.size() != 0) || m_inflight)));
   endtask

   task automatic step(input bit pv, input logic [W-1:0] pw, input bit pr, input bit dn);
      bit hs, acc;
      push_valid = pv; push_word = pw; pop_ready = pr; exec_done = dn;
      hs  = pr && (mq.size() != 0);
      acc = pv && ((mq.size() < DEPTH) || hs);
      @(posedge clk);
      if (hs) begin void'(mq.pop_front()); pops_seen++; end
      if (acc) mq.push_back(pw);
      if (hs) m_inflight = 1;
      else if (dn) m_inflight = 0;
      @(negedge clk);
      compare_all();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(pop_valid == 1'b0, "R1", W'(pop_valid), '0);
      chk(busy_n == 1'b1, "R1", W'(busy_n), W'(1));

      // R2: single push appears next cycle
      step(1, mk(1), 0, 0);
      chk(pop_valid && pop_word == mk(1), "R2", pop_word, mk(1));
      // R8: no pop while not ready
      step(0, '0, 0, 0);
      step(0, '0, 1, 0);
      // R7: busy low until done
      step(0, '0, 0, 0);
      chk(busy_n == 1'b0, "R7", W'(busy_n), '0);
      step(0, '0, 0, 1);
      chk(busy_n == 1'b1, "R7", W'(busy_n), W'(1));

      // R4 / R5: fill beyond capacity
      for (int i = 0; i < DEPTH + 6; i++) step(1, mk(100 + i), 0, 0);
      base = pops_seen;
      // R6: push and pop on full queue
      step(1, mk(999), 1, 0);
      chk(mq.size() == DEPTH && pop_valid, "R6", W'(mq.size()), W'(DEPTH));
      // drain
      while (pop_valid) step(0, '0, 1, 0);
      chk(pops_seen - base == DEPTH + 1, "R4", W'(pops_seen - base), W'(DEPTH + 1));
      step(0, '0, 0, 0);
      chk(busy_n == 1'b0, "R7", W'(busy_n), '0);
      step(0, '0, 0, 1);

      // R3: random traffic with completions
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 3) != 0, mk(2000 + i), ($urandom % 2) == 0, ($urandom % 4) == 0);
      end
      while (pop_valid) step(0, '0, 1, 0);
      step(0, '0, 0, 1);
      chk(busy_n == 1'b1 && !pop_valid, "R7", W'(busy_n), W'(1));
      finish_run();
   end
endmodule